// File: doc/BRIEF.md
# Bus Cycle Timer with Time-Stamp Generation and Match Detection

This block keeps a free-running bus cycle timer and derives time stamps from it. The timer is a 32-bit word made of three fields: a 7-bit seconds count in bits [31:25], a 13-bit cycle count in bits [24:12] that wraps at 8000, and a 12-bit offset count in bits [11:0] that wraps at 3072. The offset count advances once for every 24.576 MHz tick. The tick reaches the block as a one-cycle enable pulse `tick_in` in the block's own clock domain. When the offset count wraps, it carries into the cycle count. When the cycle count wraps, it carries into the seconds count, and the seconds count wraps at 128.

On the transmit side, a rising edge on the trigger input takes the current timer value and adds the programmed offset word to it field by field. The result is presented as the outgoing time stamp. The trigger is honoured only in the mode that uses it (`mode_dvc` = 1). In the other mode it is ignored. On the receive side, a loaded reference stamp is compared with the running cycle and offset fields, and a match gives a single pulse. Two outputs are gated by one enable: a timer clock pulse, and a pulse each time the cycle field changes. The timer can be read as two coherent 16-bit halves.

Two small state machines control the block. The stamp engine has the states SG_IDLE and SG_SUM. It goes from SG_IDLE to SG_SUM on an accepted trigger edge, and from SG_SUM back to SG_IDLE after one cycle, when it publishes the stamp. The match detector has the states MD_IDLE and MD_ARMED. A reference load moves it to MD_ARMED from either state. A hit moves it from MD_ARMED back to MD_IDLE.

Top module: `cyc_stamp_unit`

## Requirements
- R1: After reset the timer reads zero, and `stamp_out`, `stamp_vld`, `match_out`, `rd_data`, `tclk_out` and `chg_out` are all zero.
- R2: The offset field (bits [11:0]) increments by one at each clock edge that samples `tick_in` high. It holds its value at edges where `tick_in` is low.
- R3: The offset field goes from OFS_MOD-1 to 0 and carries into the cycle field (bits [24:12]). The cycle field goes from CYC_MOD-1 to 0 and carries into the seconds field (bits [31:25]). The seconds field wraps modulo 128.
- R4: When `trig_in` is first sampled high at edge k while `mode_dvc` = 1 and the stamp engine is in SG_IDLE, the timer value before edge k and `ofs_in` at edge k are captured. `stamp_vld` is then high for exactly the one cycle after edge k+1.
- R5: The stamp equals the captured timer plus the offset word, field by field. Offset fields sum modulo OFS_MOD with a carry into the cycle sum. Cycle fields sum modulo CYC_MOD with a carry into the seconds sum. The seconds sum wraps modulo 128. This is the captured linear tick index plus the offset's index, taken modulo OFS_MOD*CYC_MOD*128.
- R6: While `mode_dvc` = 0, trigger edges are ignored: `stamp_vld` stays low and `stamp_out` keeps its last value.
- R7: `chg_out` is high for the cycle after an edge where a tick wraps the offset field, which changes the cycle field, and only if `out_en` was high at that edge.
- R8: `tclk_out` is high for the cycle after each edge that samples `tick_in` and `out_en` both high. Otherwise it is low.
- R9: `rx_load` latches `rx_stamp` (cycle and offset fields, bits [24:0]) and arms the detector. The detector then pulses `match_out` for one cycle after the first edge at which timer bits [24:0] equal the reference, and disarms. A load at the same edge as a hit takes priority and suppresses that pulse.
- R10: `rd_hi` puts timer bits [31:16] on `rd_data` in the next cycle and holds bits [15:0] from the same instant. `rd_lo` later returns that held low half, even though the timer has moved on.
- R11: A trigger held high over several edges produces only one stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle timer advance enable (24.576 MHz rate) |
| out_en | input | 1 | Enables the timer clock and cycle-change outputs |
| mode_dvc | input | 1 | 1: trigger-stamp mode active; 0: trigger ignored |
| trig_in | input | 1 | Transmit time-stamp trigger, edge detected |
| ofs_in | input | 32 | Transmit offset in timer format (seconds, cycle, offset fields) |
| stamp_out | output | 32 | Outgoing time stamp |
| stamp_vld | output | 1 | One-cycle pulse when a new stamp is published |
| rx_load | input | 1 | Loads the receive reference and arms the detector |
| rx_stamp | input | 25 | Receive reference: cycle field [24:12], offset field [11:0] |
| match_out | output | 1 | One-cycle pulse when the timer reaches the reference |
| rd_hi | input | 1 | Read upper timer half; holds the lower half |
| rd_lo | input | 1 | Read the held lower half |
| rd_data | output | 16 | Read data, registered |
| tclk_out | output | 1 | Gated timer clock pulse |
| chg_out | output | 1 | Gated cycle-change pulse |

## Verification
A bad counter field first shows up at the next split read. It also shows up in the same cycle as a missing or misplaced `chg_out` pulse, because that pulse depends on where the offset field wraps. A stamp engine stuck in the wrong state either drops a stamp or sends `stamp_vld` one cycle early or late. The bench compares the pulse position and the stamp word at the exact cycle, against a linear tick count modulo the timer period. A detector that fails to disarm or to re-arm shows up within one match period (OFS_MOD*CYC_MOD ticks) as an extra or missing `match_out` pulse.

// File: rtl/cyc_stamp_pkg.sv
package cyc_stamp_pkg;

    // Transmit stamp engine states
    typedef enum logic {
        SG_IDLE = 1'b0,
        SG_SUM  = 1'b1
    } stamp_state_t;

    // Receive match detector states
    typedef enum logic {
        MD_IDLE  = 1'b0,
        MD_ARMED = 1'b1
    } match_state_t;

endpackage

// File: rtl/cyc_timer_core.sv
module cyc_timer_core #(
    parameter int SEC_W   = 7,
    parameter int CYC_W   = 13,
    parameter int OFS_W   = 12,
    parameter int CYC_MOD = 8000,
    parameter int OFS_MOD = 3072,
    localparam int TW     = SEC_W + CYC_W + OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          out_en,
    output logic [TW-1:0] tmr,
    output logic          chg_p,
    output logic          tclk_p
);
    localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(OFS_MOD - 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_MOD - 1);

    logic [SEC_W-1:0] sec_q;
    logic [CYC_W-1:0] cyc_q;
    logic [OFS_W-1:0] off_q;
    logic             off_last;
    logic             cyc_last;
    logic             chg_q;
    logic             tclk_q;

    assign off_last = (off_q == OFS_LAST);
    assign cyc_last = (cyc_q == CYC_LAST);

    // field counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            cyc_q <= '0;
            off_q <= '0;
        end else if (tick) begin
            if (off_last) begin
                off_q <= '0;
                if (cyc_last) begin
                    cyc_q <= '0;
                    sec_q <= sec_q + 1'b1;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    // gated pulse outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_q  <= 1'b0;
            tclk_q <= 1'b0;
        end else begin
            chg_q  <= tick && off_last && out_en;
            tclk_q <= tick && out_en;
        end
    end

    assign tmr    = {sec_q, cyc_q, off_q};
    assign chg_p  = chg_q;
    assign tclk_p = tclk_q;

    // R2: timer frozen when no tick
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tmr));
    // R3: fields stay below their moduli
    p_field_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q <= OFS_LAST) && (cyc_q <= CYC_LAST));
    // R8: no clock pulse while disabled
    p_tclk_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !tclk_p);
    // R7: a cycle-change pulse only coincides with a clock pulse
    p_chg_with_tclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_p |-> tclk_p);

endmodule

// File: rtl/cyc_stamp_gen.sv
module cyc_stamp_gen
    import cyc_stamp_pkg::*;
#(
    parameter int SEC_W   = 7,
    parameter int CYC_W   = 13,
    parameter int OFS_W   = 12,
    parameter int CYC_MOD = 8000,
    parameter int OFS_MOD = 3072,
    localparam int TW     = SEC_W + CYC_W + OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          mode_dvc,
    input  logic [TW-1:0] tmr,
    input  logic [TW-1:0] ofs,
    output logic [TW-1:0] stamp,
    output logic          vld
);
    localparam int CYC_LO = OFS_W;
    localparam int SEC_LO = OFS_W + CYC_W;
    localparam logic [OFS_W:0] OFS_LIM = (OFS_W + 1)'(OFS_MOD);
    localparam logic [CYC_W:0] CYC_LIM = (CYC_W + 1)'(CYC_MOD);

    stamp_state_t st_q, st_d;
    logic          trig_d;
    logic          fire;
    logic [TW-1:0] cap_q;
    logic [TW-1:0] cofs_q;
    logic [TW-1:0] stamp_q;
    logic          vld_q;

    logic [OFS_W:0]   o_sum, o_res;
    logic             o_car;
    logic [CYC_W:0]   c_sum, c_res;
    logic             c_car;
    logic [SEC_W-1:0] s_res;
    logic [TW-1:0]    sum_w;

    assign fire = trig && !trig_d && mode_dvc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SG_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SG_IDLE: if (fire) st_d = SG_SUM;
            SG_SUM:  st_d = SG_IDLE;
            default: st_d = SG_IDLE;
        endcase
    end

    // field-wise modular adder
    always_comb begin
        o_sum = {1'b0, cap_q[OFS_W-1:0]} + {1'b0, cofs_q[OFS_W-1:0]};
        o_car = (o_sum >= OFS_LIM);
        o_res = o_car ? (o_sum - OFS_LIM) : o_sum;
        c_sum = {1'b0, cap_q[SEC_LO-1:CYC_LO]} + {1'b0, cofs_q[SEC_LO-1:CYC_LO]}
              + {{CYC_W{1'b0}}, o_car};
        c_car = (c_sum >= CYC_LIM);
        c_res = c_car ? (c_sum - CYC_LIM) : c_sum;
        s_res = cap_q[TW-1:SEC_LO] + cofs_q[TW-1:SEC_LO]
              + {{(SEC_W-1){1'b0}}, c_car};
        sum_w = {s_res, c_res[CYC_W-1:0], o_res[OFS_W-1:0]};
    end

    // outputs and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_d  <= 1'b0;
            cap_q   <= '0;
            cofs_q  <= '0;
            stamp_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            trig_d <= trig;
            vld_q  <= 1'b0;
            unique case (st_q)
                SG_IDLE: begin
                    if (fire) begin
                        cap_q  <= tmr;
                        cofs_q <= ofs;
                    end
                end
                SG_SUM: begin
                    stamp_q <= sum_w;
                    vld_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign stamp = stamp_q;
    assign vld   = vld_q;

    // R4: publication is a single-cycle pulse
    p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);
    // R4: summing only follows a trigger seen high in trigger mode
    p_sum_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SG_SUM) |-> $past(trig && mode_dvc));
    // R6: idle engine stays idle with the trigger mode off
    p_mode_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SG_IDLE && !mode_dvc) |=> (st_q == SG_IDLE));
    // R11: two sums are never back to back
    p_no_double_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SG_SUM) |=> (st_q == SG_IDLE));

endmodule

// File: rtl/cyc_match_det.sv
module cyc_match_det
    import cyc_stamp_pkg::*;
#(
    parameter int CMP_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] tmr_lo,
    input  logic             rx_load,
    input  logic [CMP_W-1:0] rx_ref,
    output logic             match
);
    match_state_t     st_q, st_d;
    logic [CMP_W-1:0] ref_q;
    logic             hit;
    logic             match_q;

    assign hit = (st_q == MD_ARMED) && (tmr_lo == ref_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MD_IDLE;
        else        st_q <= st_d;
    end

    // next state: a load wins over a hit
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MD_IDLE:  if (rx_load) st_d = MD_ARMED;
            MD_ARMED: if (!rx_load && hit) st_d = MD_IDLE;
            default:  st_d = MD_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            match_q <= 1'b0;
        end else begin
            if (rx_load) ref_q <= rx_ref;
            match_q <= hit && !rx_load;
        end
    end

    assign match = match_q;

    // R9: single pulse per arming
    p_match_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);
    // R9: a reported hit leaves the detector disarmed
    p_match_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (st_q == MD_IDLE));

endmodule

// File: rtl/cyc_split_read.sv
module cyc_split_read #(
    parameter int TW = 32,
    localparam int HW = TW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmr,
    input  logic          rd_hi,
    input  logic          rd_lo,
    output logic [HW-1:0] rd_data
);
    logic [HW-1:0] hold_q;
    logic [HW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            data_q <= '0;
        end else if (rd_hi) begin
            data_q <= tmr[TW-1:HW];
            hold_q <= tmr[HW-1:0];
        end else if (rd_lo) begin
            data_q <= hold_q;
        end
    end

    assign rd_data = data_q;

    // R10: the held half is untouched between reads
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hi |=> $stable(hold_q));

endmodule

// File: rtl/cyc_stamp_unit.sv
module cyc_stamp_unit #(
    parameter int SEC_W   = 7,
    parameter int CYC_W   = 13,
    parameter int OFS_W   = 12,
    parameter int CYC_MOD = 8000,
    parameter int OFS_MOD = 3072,
    localparam int TW     = SEC_W + CYC_W + OFS_W,
    localparam int CMP_W  = CYC_W + OFS_W,
    localparam int HW     = TW / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             out_en,
    input  logic             mode_dvc,
    input  logic             trig_in,
    input  logic [TW-1:0]    ofs_in,
    output logic [TW-1:0]    stamp_out,
    output logic             stamp_vld,
    input  logic             rx_load,
    input  logic [CMP_W-1:0] rx_stamp,
    output logic             match_out,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [HW-1:0]    rd_data,
    output logic             tclk_out,
    output logic             chg_out
);
    logic [TW-1:0] tmr;

    cyc_timer_core #(
        .SEC_W(SEC_W), .CYC_W(CYC_W), .OFS_W(OFS_W),
        .CYC_MOD(CYC_MOD), .OFS_MOD(OFS_MOD)
    ) core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_in), .out_en(out_en),
        .tmr(tmr), .chg_p(chg_out), .tclk_p(tclk_out)
    );

    cyc_stamp_gen #(
        .SEC_W(SEC_W), .CYC_W(CYC_W), .OFS_W(OFS_W),
        .CYC_MOD(CYC_MOD), .OFS_MOD(OFS_MOD)
    ) gen_i (
        .clk(clk), .rst_n(rst_n), .trig(trig_in), .mode_dvc(mode_dvc),
        .tmr(tmr), .ofs(ofs_in), .stamp(stamp_out), .vld(stamp_vld)
    );

    cyc_match_det #(
        .CMP_W(CMP_W)
    ) det_i (
        .clk(clk), .rst_n(rst_n), .tmr_lo(tmr[CMP_W-1:0]),
        .rx_load(rx_load), .rx_ref(rx_stamp), .match(match_out)
    );

    cyc_split_read #(
        .TW(TW)
    ) rd_i (
        .clk(clk), .rst_n(rst_n), .tmr(tmr),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data)
    );

endmodule

// File: tb/cyc_stamp_unit_tb_top.sv
module cyc_stamp_unit_tb_top;
    localparam int OM  = 5;
    localparam int CM  = 4;
    localparam int LOW = OM * CM;
    localparam int PER = LOW * 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0, out_en = 1'b0, mode_dvc = 1'b0, trig_in = 1'b0;
    logic [31:0] ofs_in = '0;
    logic [31:0] stamp_out;
    logic        stamp_vld;
    logic        rx_load = 1'b0;
    logic [24:0] rx_stamp = '0;
    logic        match_out;
    logic        rd_hi = 1'b0, rd_lo = 1'b0;
    logic [15:0] rd_data;
    logic        tclk_out, chg_out;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    // bench model state
    int nt = 0;
    int pre = 0;
    int ofs_idx = 0;
    bit trig_prev = 1'b0;
    bit sum_pend = 1'b0;
    logic [31:0] pend_val = '0;
    logic [31:0] last_stamp = '0;
    bit armed = 1'b0;
    int ref_low = 0;

    always #10 clk = ~clk;

    cyc_stamp_unit #(.CYC_MOD(CM), .OFS_MOD(OM)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .out_en(out_en),
        .mode_dvc(mode_dvc), .trig_in(trig_in), .ofs_in(ofs_in),
        .stamp_out(stamp_out), .stamp_vld(stamp_vld),
        .rx_load(rx_load), .rx_stamp(rx_stamp), .match_out(match_out),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data),
        .tclk_out(tclk_out), .chg_out(chg_out)
    );

    function automatic logic [31:0] enc(input int n);
        int o, c, s;
        o = n % OM;
        c = (n / OM) % CM;
        s = (n / LOW) % 128;
        return {s[6:0], c[12:0], o[11:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: inputs already set; model follows; outputs checked at negedge
    task automatic adv();
        bit t_now, e_now, fire_now, ld_now, exp_match, exp_vld;
        int ref_now;
        @(posedge clk);
        pre = nt;
        t_now = tick_in;
        e_now = out_en;
        ld_now = rx_load;
        ref_now = int'(rx_stamp[24:12]) * OM + int'(rx_stamp[11:0]);
        fire_now = trig_in && !trig_prev && mode_dvc;
        trig_prev = trig_in;
        if (tick_in) nt++;
        // stamp engine model
        exp_vld = sum_pend;
        if (sum_pend) last_stamp = pend_val;
        if (!sum_pend && fire_now) begin
            sum_pend = 1'b1;
            pend_val = enc((pre + ofs_idx) % PER);
        end else begin
            sum_pend = 1'b0;
        end
        // match model
        exp_match = 1'b0;
        if (ld_now) begin
            armed = 1'b1;
            ref_low = ref_now;
        end else if (armed && (pre % LOW) == ref_low) begin
            exp_match = 1'b1;
            armed = 1'b0;
        end
        @(negedge clk);
        chk(tclk_out == (t_now && e_now), "R8", {31'b0, tclk_out}, {31'b0, t_now && e_now});
        chk(chg_out == (t_now && e_now && (pre % OM) == OM - 1), "R7",
            {31'b0, chg_out}, {31'b0, t_now && e_now && (pre % OM) == OM - 1});
        chk(match_out == exp_match, "R9", {31'b0, match_out}, {31'b0, exp_match});
        chk(stamp_vld == exp_vld, mode_dvc ? "R4" : "R6", {31'b0, stamp_vld}, {31'b0, exp_vld});
        chk(stamp_out == last_stamp, exp_vld ? "R5" : "R11", stamp_out, last_stamp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        int offs [6];
        offs = '{0, 1, OM - 1, LOW - 1, PER - 1, 1234};
        held = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk(stamp_out == 0 && !stamp_vld && !match_out && rd_data == 0
            && !tclk_out && !chg_out, "R1",
            {stamp_out[15:0], rd_data}, 32'h0);
        rd_hi = 1'b1;
        adv();
        rd_hi = 1'b0;
        chk(rd_data == 16'h0, "R1", {16'h0, rd_data}, 32'h0);
        rd_lo = 1'b1;
        adv();
        rd_lo = 1'b0;
        chk(rd_data == 16'h0, "R1", {16'h0, rd_data}, 32'h0);

        for (int i = 0; i < 4000; i++) begin
            tick_in  = (i < 1500) ? 1'b1 : (i % 3 != 0);
            out_en   = ((i / 200) % 2 == 0);
            mode_dvc = ((i / 50) % 4 != 3);
            trig_in  = (i % 50 >= 10) && (i % 50 < 15);
            ofs_idx  = offs[(i / 50) % 6];
            ofs_in   = enc(ofs_idx);
            rd_hi    = (i % 11 == 0);
            rd_lo    = (i % 11 == 1);
            rx_load  = (i % 97 == 5) || (i % 97 == 40);
            rx_stamp = enc((i * 7) % LOW)[24:0];
            adv();
            if (i % 11 == 0) begin
                chk(rd_data == enc(pre)[31:16], (i < 1500) ? "R3" : "R2",
                    {16'h0, rd_data}, {16'h0, enc(pre)[31:16]});
                held = enc(pre)[15:0];
            end else if (i % 11 == 1) begin
                chk(rd_data == held, "R10", {16'h0, rd_data}, {16'h0, held});
            end
        end

        // R3: seconds field wrapped past 127 during the sweep
        chk(nt > PER, "R3", nt, PER);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule